// File: doc/BRIEF.md
# Two-Stage Watchdog Countdown Engine

This block is the timing core of a system watchdog. Once armed, it counts down a first period and then fires an interrupt-style action. It then counts down a second period and, if allowed, requests a system reset. Software refreshes the count by kicking it. Each period comes from a 20-bit preload multiplied by one of two power-of-two prescale factors, so one counter covers both millisecond-range and microsecond-range timeouts from a 33 MHz clock.

The block receives the configuration and the arm, kick and stop requests as plain levels and single-cycle pulses. It returns single-cycle action pulses and the number of the current stage. An optional loop mode starts the first period again after the second one expires, so the engine keeps running without software.

Top module: `wdt2_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `stage_o` reads 0 (idle), and `irq_pulse`, `sys_mgmt_pulse`, `reset_req` and `boot_mark` are all low. `stage_o` never reads 3.
- R2: With `wd_enable` high and `halt_req` low, a cycle with `arm_req` or `kick_req` high loads the first period from `first_preload`, and `stage_o` reads 1 from the next cycle on.
- R3: A period of preload P lasts P·32768 counting cycles when `fast_scale` is 0 and P·32 when it is 1. The first-stage action pulse appears exactly T1+2 sampled cycles after the cycle in which the arm request was driven, where T1 is the scaled first preload.
- R4: At the end of the first period, `action_sel` = 0 gives one `irq_pulse` and `action_sel` = 2 gives one `sys_mgmt_pulse`. Codes 1 and 3 give no pulse. In the same cycle `stage_o` becomes 2 and the second period is loaded from `second_preload`.
- R5: The second-stage end comes exactly T2+1 cycles after the first-stage action pulse, where T2 is the scaled second preload.
- R6: When the second period ends with `reset_enable` high, `reset_req` and `boot_mark` pulse together for one cycle. Without loop mode, `stage_o` returns to 0 at the same time. With `reset_enable` low, neither of them pulses.
- R7: When the second period ends with `loop_mode` high, `stage_o` returns to 1 and the first period is reloaded.
- R8: A kick while enabled reloads the first period and sets `stage_o` to 1 in any stage, including stage 2.
- R9: While `wd_enable` is low, arm and kick requests are ignored: `stage_o` stays 0. Dropping `wd_enable` halts counting in the next cycle.
- R10: `halt_req` sets `stage_o` to 0 in the next cycle and suppresses any action due in that cycle. It wins over a kick or arm in the same cycle.
- R11: A preload of zero ends its period one cycle after it is loaded.
- R12: Every action output is high for at most one consecutive cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, nominally 33 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| wd_enable | input | 1 | Watchdog enable level |
| arm_req | input | 1 | Start counting the first period |
| kick_req | input | 1 | Refresh: reload the first period |
| halt_req | input | 1 | Stop counting now |
| first_preload | input | 20 | First-period preload |
| second_preload | input | 20 | Second-period preload |
| fast_scale | input | 1 | 1: multiply by 32, 0: multiply by 32768 |
| action_sel | input | 2 | First-stage action: 0 irq, 2 sys-mgmt, else none |
| reset_enable | input | 1 | Allow the reset request at the end of the second period |
| loop_mode | input | 1 | Restart the first period after the second |
| irq_pulse | output | 1 | First-stage interrupt pulse |
| sys_mgmt_pulse | output | 1 | First-stage system-management pulse |
| reset_req | output | 1 | Reset request pulse |
| boot_mark | output | 1 | Pulse that sets the previous-reboot flag |
| stage_o | output | 2 | Current stage: 0 idle, 1 first, 2 second |

## Verification
A wrong stage register or a wrong reload choice shows up directly on `stage_o` in the cycle after the edge that caused it. This makes kick, stop and loop errors visible within one cycle. A wrong count or prescale is silent until the period ends, where the action pulse arrives early or late. The bench therefore measures the exact cycle of each pulse, and it runs a cycle-by-cycle reference model that compares every output on every cycle. Most test periods use the fast scale, so a count error appears within a few hundred cycles; one slow-scale period confirms the long shift.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } stage_e;

  localparam logic [1:0] ACT_IRQ = 2'd0;
  localparam logic [1:0] ACT_SMI = 2'd2;

  localparam int FIRE_N = 4;
  localparam int F_IRQ  = 0;
  localparam int F_SMI  = 1;
  localparam int F_RST  = 2;
  localparam int F_MARK = 3;
endpackage

// File: rtl/wdt2_counter.sv
module wdt2_counter #(
  parameter int PRE_W   = 20,
  parameter int SLOW_SH = 15,
  parameter int FAST_SH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_first,
  input  logic             load_second,
  input  logic             tick,
  input  logic [PRE_W-1:0] pre_first,
  input  logic [PRE_W-1:0] pre_second,
  input  logic             fast_scale,
  output logic             cnt_zero
);
  localparam int CNT_W = PRE_W + SLOW_SH;

  // Scaled period length in counting cycles.
  function automatic logic [CNT_W-1:0] span(input logic [PRE_W-1:0] pre,
                                            input logic fast);
    logic [CNT_W-1:0] wide;
    wide = {{SLOW_SH{1'b0}}, pre};
    return fast ? (wide << FAST_SH) : (wide << SLOW_SH);
  endfunction

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load_first)  cnt_q <= span(pre_first, fast_scale);
    else if (load_second) cnt_q <= span(pre_second, fast_scale);
    else if (tick)        cnt_q <= cnt_q - CNT_W'(1);
  end

  assign cnt_zero = (cnt_q == '0);
endmodule

// File: rtl/wdt2_seq.sv
module wdt2_seq
  import wdt2_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wd_enable,
  input  logic   arm_req,
  input  logic   kick_req,
  input  logic   halt_req,
  input  logic   loop_mode,
  input  logic   cnt_zero,
  output stage_e stage_q,
  output logic   halt,
  output logic   load_first,
  output logic   load_second,
  output logic   expire_first,
  output logic   expire_second,
  output logic   tick
);
  logic   arm;
  logic   live;
  stage_e stage_d;

  // Priority: halt, then arm/kick, then expiry/countdown.
  assign halt          = !wd_enable || halt_req;
  assign arm           = !halt && (arm_req || kick_req);
  assign live          = !halt && !arm && (stage_q != ST_IDLE);
  assign expire_first  = live && (stage_q == ST_FIRST)  && cnt_zero;
  assign expire_second = live && (stage_q == ST_SECOND) && cnt_zero;
  assign tick          = live && !cnt_zero;
  assign load_first    = arm || (expire_second && loop_mode);
  assign load_second   = expire_first;

  always_comb begin
    stage_d = stage_q;
    if (halt)               stage_d = ST_IDLE;
    else if (load_first)    stage_d = ST_FIRST;
    else if (load_second)   stage_d = ST_SECOND;
    else if (expire_second) stage_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= ST_IDLE;
    else        stage_q <= stage_d;
  end
endmodule

// File: rtl/wdt2_action.sv
module wdt2_action
  import wdt2_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              expire_first,
  input  logic              expire_second,
  input  logic [1:0]        action_sel,
  input  logic              reset_enable,
  output logic [FIRE_N-1:0] fire_q
);
  logic [FIRE_N-1:0] fire_d;

  always_comb begin
    fire_d         = '0;
    fire_d[F_IRQ]  = expire_first && (action_sel == ACT_IRQ);
    fire_d[F_SMI]  = expire_first && (action_sel == ACT_SMI);
    fire_d[F_RST]  = expire_second && reset_enable;
    fire_d[F_MARK] = expire_second && reset_enable;
  end

  for (genvar g = 0; g < FIRE_N; g++) begin : g_fire
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= fire_d[g];
    end
    assign fire_q[g] = q;
  end
endmodule

// File: rtl/wdt2_engine.sv
module wdt2_engine
  import wdt2_pkg::*;
#(
  parameter int PRE_W   = 20,
  parameter int SLOW_SH = 15,
  parameter int FAST_SH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wd_enable,
  input  logic             arm_req,
  input  logic             kick_req,
  input  logic             halt_req,
  input  logic [PRE_W-1:0] first_preload,
  input  logic [PRE_W-1:0] second_preload,
  input  logic             fast_scale,
  input  logic [1:0]       action_sel,
  input  logic             reset_enable,
  input  logic             loop_mode,
  output logic             irq_pulse,
  output logic             sys_mgmt_pulse,
  output logic             reset_req,
  output logic             boot_mark,
  output logic [1:0]       stage_o
);
  stage_e            stage_q;
  logic              halt;
  logic              load_first;
  logic              load_second;
  logic              expire_first;
  logic              expire_second;
  logic              tick;
  logic              cnt_zero;
  logic [FIRE_N-1:0] fire_q;

  wdt2_seq u_seq (
    .clk(clk), .rst_n(rst_n), .wd_enable(wd_enable), .arm_req(arm_req),
    .kick_req(kick_req), .halt_req(halt_req), .loop_mode(loop_mode),
    .cnt_zero(cnt_zero), .stage_q(stage_q), .halt(halt),
    .load_first(load_first), .load_second(load_second),
    .expire_first(expire_first), .expire_second(expire_second), .tick(tick)
  );

  wdt2_counter #(.PRE_W(PRE_W), .SLOW_SH(SLOW_SH), .FAST_SH(FAST_SH)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_first(load_first),
    .load_second(load_second), .tick(tick), .pre_first(first_preload),
    .pre_second(second_preload), .fast_scale(fast_scale), .cnt_zero(cnt_zero)
  );

  wdt2_action u_act (
    .clk(clk), .rst_n(rst_n), .expire_first(expire_first),
    .expire_second(expire_second), .action_sel(action_sel),
    .reset_enable(reset_enable), .fire_q(fire_q)
  );

  assign irq_pulse      = fire_q[F_IRQ];
  assign sys_mgmt_pulse = fire_q[F_SMI];
  assign reset_req      = fire_q[F_RST];
  assign boot_mark      = fire_q[F_MARK];
  assign stage_o        = stage_q;
endmodule

// File: rtl/wdt2_engine_chk.sv
module wdt2_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wd_enable,
  input logic       kick_req,
  input logic       halt_req,
  input logic       loop_mode,
  input logic       irq_pulse,
  input logic       sys_mgmt_pulse,
  input logic       reset_req,
  input logic       boot_mark,
  input logic [1:0] stage_o,
  input logic       expire_first,
  input logic       expire_second
);
  a_r1_stage_legal: assert property (@(posedge clk) disable iff (!rst_n)
    stage_o != 2'd3);

  a_r4_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_pulse && sys_mgmt_pulse));

  a_r4_action_in_second: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse || sys_mgmt_pulse) |-> stage_o == 2'd2);

  a_r4_first_end_enters_second: assert property (@(posedge clk) disable iff (!rst_n)
    expire_first |=> stage_o == 2'd2);

  a_r6_mark_with_reset: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> boot_mark);

  a_r6_reset_leaves_second: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> stage_o != 2'd2);

  a_r7_loop_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_second && loop_mode) |=> stage_o == 2'd1);

  a_r8_kick_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_enable && kick_req && !halt_req) |=> stage_o == 2'd1);

  a_r9_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_enable |=> stage_o == 2'd0);

  a_r10_halt_silences: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |=> (stage_o == 2'd0 && !irq_pulse && !sys_mgmt_pulse && !reset_req));

  a_r12_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  a_r12_reset_single: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);
endmodule

bind wdt2_engine wdt2_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wd_enable(wd_enable), .kick_req(kick_req),
  .halt_req(halt_req), .loop_mode(loop_mode), .irq_pulse(irq_pulse),
  .sys_mgmt_pulse(sys_mgmt_pulse), .reset_req(reset_req),
  .boot_mark(boot_mark), .stage_o(stage_o), .expire_first(expire_first),
  .expire_second(expire_second)
);

// File: tb/wdt2_engine_tb.sv
module wdt2_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wd_enable = 1'b0, arm_req = 1'b0, kick_req = 1'b0, halt_req = 1'b0;
  logic [19:0] first_preload = '0, second_preload = '0;
  logic        fast_scale = 1'b1;
  logic [1:0]  action_sel = 2'd0;
  logic        reset_enable = 1'b0, loop_mode = 1'b0;
  logic        irq_pulse, sys_mgmt_pulse, reset_req, boot_mark;
  logic [1:0]  stage_o;

  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  wdt2_engine u_dut (
    .clk(clk), .rst_n(rst_n), .wd_enable(wd_enable), .arm_req(arm_req),
    .kick_req(kick_req), .halt_req(halt_req), .first_preload(first_preload),
    .second_preload(second_preload), .fast_scale(fast_scale),
    .action_sel(action_sel), .reset_enable(reset_enable),
    .loop_mode(loop_mode), .irq_pulse(irq_pulse),
    .sys_mgmt_pulse(sys_mgmt_pulse), .reset_req(reset_req),
    .boot_mark(boot_mark), .stage_o(stage_o)
  );

  function automatic longint span(input int unsigned p, input bit f);
    return longint'(p) * (f ? 64'd32 : 64'd32768);
  endfunction

  // Reference model, stepped at every rising edge from the sampled inputs.
  int     m_stage;
  longint m_left;
  bit     m_irq, m_smi, m_rst, m_mark;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stage = 0; m_left = 0; m_irq = 0; m_smi = 0; m_rst = 0; m_mark = 0;
    end else begin
      m_irq = 0; m_smi = 0; m_rst = 0; m_mark = 0;
      if (!wd_enable || halt_req) m_stage = 0;
      else if (arm_req || kick_req) begin
        m_stage = 1; m_left = span(first_preload, fast_scale);
      end else if (m_stage != 0) begin
        if (m_left == 0) begin
          if (m_stage == 1) begin
            m_irq = (action_sel == 2'd0);
            m_smi = (action_sel == 2'd2);
            m_stage = 2; m_left = span(second_preload, fast_scale);
          end else begin
            m_rst = reset_enable; m_mark = reset_enable;
            if (loop_mode) begin
              m_stage = 1; m_left = span(first_preload, fast_scale);
            end else m_stage = 0;
          end
        end else m_left = m_left - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rst_n) begin
        chk(stage_o == m_stage[1:0], "R2", "model stage", stage_o, m_stage);
        chk(irq_pulse == m_irq, "R4", "model irq", irq_pulse, m_irq);
        chk(sys_mgmt_pulse == m_smi, "R4", "model sys_mgmt", sys_mgmt_pulse, m_smi);
        chk(reset_req == m_rst, "R6", "model reset_req", reset_req, m_rst);
        chk(boot_mark == m_mark, "R6", "model boot_mark", boot_mark, m_mark);
      end
    end
  endtask

  task automatic cfg(input int p1, input int p2, input bit f, input int sel,
                     input bit rb, input bit lp);
    first_preload = 20'(p1); second_preload = 20'(p2); fast_scale = f;
    action_sel = 2'(sel); reset_enable = rb; loop_mode = lp;
  endtask

  task automatic stop_all();
    halt_req = 1; step(1); halt_req = 0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL R1 watchdog expired actual %0d expected %0d", 200000, 0);
    finish_run();
  end

  initial begin
    int k;
    bit saw21, saw_rst, dbl, saw_irq;
    void'($urandom(32'd2024));
    @(negedge clk);
    chk(stage_o == 0 && !irq_pulse && !reset_req && !boot_mark && !sys_mgmt_pulse,
        "R1", "outputs in reset", stage_o, 0);
    @(negedge clk);
    rst_n = 1;
    step(1);
    chk(stage_o == 0 && !irq_pulse && !reset_req, "R1", "stage after reset", stage_o, 0);

    // R9: disabled ignores arm and kick
    wd_enable = 0; arm_req = 1; kick_req = 1; step(3); arm_req = 0; kick_req = 0;
    chk(stage_o == 0, "R9", "stage while disabled", stage_o, 0);
    wd_enable = 1;

    // R11 / R2 / R4 / R6: zero preloads
    cfg(0, 0, 1, 0, 1, 0);
    arm_req = 1; step(1); arm_req = 0;
    chk(stage_o == 1, "R2", "stage after arm", stage_o, 1);
    step(1);
    chk(irq_pulse == 1, "R11", "zero preload irq", irq_pulse, 1);
    chk(stage_o == 2, "R4", "stage after first end", stage_o, 2);
    step(1);
    chk(reset_req && boot_mark, "R6", "reset and mark", {reset_req, boot_mark}, 3);
    chk(stage_o == 0, "R6", "idle after reset", stage_o, 0);
    step(1);
    chk(!irq_pulse && !reset_req, "R12", "pulses dropped", {irq_pulse, reset_req}, 0);

    // R5: second-stage length
    cfg(0, 3, 1, 2, 1, 0);
    arm_req = 1; step(1); arm_req = 0; step(1);
    chk(sys_mgmt_pulse == 1, "R4", "sys_mgmt for code 2", sys_mgmt_pulse, 1);
    k = 0;
    while (!reset_req && k < 1000) begin step(1); k++; end
    chk(k == 97, "R5", "second period cycles", k, 97);

    // R3: fast and slow scale
    cfg(1, 0, 1, 0, 0, 0);
    arm_req = 1; step(1); arm_req = 0; k = 1;
    while (!irq_pulse && k < 1000) begin step(1); k++; end
    chk(k == 34, "R3", "fast first period", k, 34);
    step(3);
    cfg(1, 0, 0, 2, 0, 0);
    arm_req = 1; step(1); arm_req = 0; k = 1;
    while (!sys_mgmt_pulse && k < 40000) begin step(1); k++; end
    chk(k == 32770, "R3", "slow first period", k, 32770);
    step(3);

    // R8: kick during stage 2, code 3 gives no action
    cfg(1, 10, 1, 3, 1, 0);
    arm_req = 1; step(1); arm_req = 0; k = 0;
    while (stage_o != 2 && k < 1000) begin step(1); k++; end
    chk(!irq_pulse && !sys_mgmt_pulse, "R4", "no action for code 3",
        {irq_pulse, sys_mgmt_pulse}, 0);
    step(5);
    kick_req = 1; step(1); kick_req = 0;
    chk(stage_o == 1, "R8", "kick in stage 2", stage_o, 1);
    k = 0;
    while (stage_o == 1 && k < 1000) begin step(1); k++; end
    chk(k == 33, "R8", "reloaded first period", k, 33);
    halt_req = 1; kick_req = 1; step(1); halt_req = 0; kick_req = 0;
    chk(stage_o == 0, "R10", "halt beats kick", stage_o, 0);

    // R10: halt in the expiry cycle
    cfg(0, 0, 1, 0, 1, 0);
    arm_req = 1; step(1); arm_req = 0;
    halt_req = 1; step(1); halt_req = 0;
    chk(!irq_pulse && stage_o == 0, "R10", "halt suppresses action", irq_pulse, 0);

    // R9: dropping enable halts
    arm_req = 1; cfg(5, 5, 1, 0, 1, 0); step(1); arm_req = 0; step(3);
    wd_enable = 0; step(1);
    chk(stage_o == 0, "R9", "enable low halts", stage_o, 0);
    wd_enable = 1;

    // R7: loop mode without reset
    cfg(2, 1, 1, 0, 0, 1);
    arm_req = 1; step(1); arm_req = 0;
    saw21 = 0; saw_rst = 0;
    for (int i = 0; i < 400; i++) begin
      int prev;
      prev = stage_o;
      step(1);
      if (prev == 2 && stage_o == 1) saw21 = 1;
      if (reset_req || boot_mark) saw_rst = 1;
    end
    chk(saw21 && !saw_rst, "R7", "loop rearm without reset", {saw21, saw_rst}, 2);
    stop_all();

    // R12: back-to-back zero periods
    cfg(0, 0, 1, 0, 1, 1);
    arm_req = 1; step(1); arm_req = 0;
    dbl = 0; saw_irq = 0;
    for (int i = 0; i < 30; i++) begin
      bit pi, pr;
      pi = irq_pulse; pr = reset_req;
      step(1);
      if ((pi && irq_pulse) || (pr && reset_req)) dbl = 1;
      if (irq_pulse) saw_irq = 1;
    end
    chk(!dbl && saw_irq, "R12", "single-cycle pulses", {dbl, saw_irq}, 1);
    stop_all();

    // Random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      wd_enable = ($urandom % 50) != 0;
      arm_req   = ($urandom % 40) == 0;
      kick_req  = ($urandom % 60) == 0;
      halt_req  = ($urandom % 150) == 0;
      fast_scale = ($urandom % 20) != 0;
      first_preload  = fast_scale ? 20'($urandom % 8) : 20'd0;
      second_preload = fast_scale ? 20'($urandom % 8) : 20'd0;
      if (($urandom % 30) == 0) begin
        action_sel = 2'($urandom % 4);
        reset_enable = 1'($urandom % 2);
        loop_mode = 1'($urandom % 2);
      end
      step(1);
    end
    arm_req = 0; kick_req = 0; halt_req = 0; wd_enable = 1;
    step(2);
    finish_run();
  end
endmodule